// File: doc/BRIEF.md
# I2C Message Transaction Sequencer

This block sits in front of an I2C master controller whose command FIFO takes one word per byte. A client hands it a transaction as a list of message descriptors. Each descriptor carries a 7-bit target address, a direction, a byte count and a flag that marks the final message. The sequencer expands the list into command words. Write bytes come from a separate byte stream. Read bytes arrive from the master's receive FIFO and are forwarded on a read-data stream. The master's FIFO and abort flags are watched so that each message can be confirmed before the next one begins.

Bus framing follows the message list. A repeated START is requested whenever a message targets a different address, or runs in the other direction, from the message before it. A STOP is requested only with the final byte of the final message. Every wait on the master is bounded by a cycle-count timeout. The first error ends the work on the transaction. The rest of the descriptors, and any write bytes they own, are still consumed so that the client's streams stay aligned. A one-cycle done pulse then presents the ORed error status.

Top module: `i2c_msg_seq`

## Requirements
- R1: After reset the block accepts a descriptor (`msgReady`=1) and drives `cmdValid`=0 and `done`=0.
- R2: Each byte of a message produces one command word with this layout: bits [7:0] data, bit [8] zero, bits [15:9] target address, bit [16] read (1 = read), bit [17] STOP request, bit [18] repeated-START request. Write bytes are taken from the write stream in order. Read commands carry data 0x00.
- R3: The first message of a transaction never requests a repeated START. A later message requests one on its first byte only, and only if its address or direction differs from the message before it. That message then becomes the reference for the next comparison.
- R4: STOP is requested only on the last byte of the message marked final. No command follows it within the transaction.
- R5: When a write message has queued all of its bytes, the block waits for the master's transmit FIFO to be empty and then samples the abort flag. If the abort flag is set, a data NACK source gives code 0x02. Otherwise an address NACK source gives 0x01. With neither source set, the code is 0x10.
- R6: A read message issues one read command per byte and waits for the receive FIFO to be non-empty before each next command. The block pops each byte and presents it on `rdValid`/`rdData`. An address NACK seen during that wait ends the message with code 0x01.
- R7: If a wait makes no progress for TIMEOUT_CYC cycles, the message fails with code 0x08. This covers a full command FIFO, transmit-empty and receive-not-empty.
- R8: After the first error, no further command is issued. The unsent write bytes of the failing message are consumed and dropped. Later descriptors up to the final one are accepted, and their write bytes are dropped.
- R9: A zero-length message issues no command and fails the transaction with code 0x10.
- R10: At the end of a transaction `done` is high for exactly one cycle, with `status` holding the OR of all error codes (0x00 on success). Status is cleared for the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msgValid | input | 1 | Descriptor offered |
| msgReady | output | 1 | Descriptor accepted when high with msgValid |
| msgAddr | input | 7 | Target address of the message |
| msgRead | input | 1 | 1 = read message, 0 = write message |
| msgLen | input | LEN_W | Byte count of the message |
| msgLast | input | 1 | Marks the final message of the transaction |
| wrValid | input | 1 | Write byte offered |
| wrReady | output | 1 | Write byte consumed |
| wrData | input | 8 | Write byte |
| rdValid | output | 1 | Read byte presented for one cycle |
| rdData | output | 8 | Read byte |
| cmdValid | output | 1 | Command word offered to the master |
| cmdReady | input | 1 | Master command FIFO not full |
| cmdWord | output | 19 | Command word (layout in R2) |
| txEmpty | input | 1 | Master transmit FIFO empty |
| txAbort | input | 1 | Master reports an aborted transfer |
| abrtAddrNack | input | 1 | Abort source: address not acknowledged |
| abrtDataNack | input | 1 | Abort source: data byte not acknowledged |
| rxNotEmpty | input | 1 | Master receive FIFO holds a byte |
| rxData | input | 8 | Head of the master receive FIFO |
| rxPop | output | 1 | Pops the receive FIFO |
| done | output | 1 | One-cycle end-of-transaction pulse |
| status | output | 5 | ORed error code, valid with done |

## Verification
The bench builds the block with LEN_W = 4 and TIMEOUT_CYC = 24. With a 24-cycle window, a stuck command FIFO or a silent receive FIFO reaches the timeout path within a few dozen cycles instead of millions. The bench's master model has a three-entry command FIFO that drains one word every third cycle. Multi-byte messages therefore run into real backpressure. The timeout only fires when the model is frozen on purpose, which keeps both stall paths and the drain-after-error path within a short run.

// File: rtl/i2cseq_pkg.sv
`timescale 1ns/1ps
package i2cseq_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int STAT_W = 5;

  localparam logic [STAT_W-1:0] ST_ADDR_NACK   = 5'h01;
  localparam logic [STAT_W-1:0] ST_DATA_NACK   = 5'h02;
  localparam logic [STAT_W-1:0] ST_SEQ_TIMEOUT = 5'h08;
  localparam logic [STAT_W-1:0] ST_ABORT       = 5'h10;

  typedef struct packed {
    logic              restart;
    logic              stop;
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic              rsvd;
    logic [BYTE_W-1:0] data;
  } cmdWord_t;

  localparam int CMD_W = $bits(cmdWord_t);

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT_TX, S_WAIT_RX, S_SKIP, S_FINISH
  } seqState_t;

  typedef struct packed {
    logic              loadMsg;
    logic              cmdSent;
    logic              decRem;
    logic              tmrClr;
    logic              tmrInc;
    logic              errSet;
    logic [STAT_W-1:0] errCode;
    logic              txnClr;
  } seqStrobe_t;
endpackage

// File: rtl/i2cseq_ctrl.sv
`timescale 1ns/1ps
module i2cseq_ctrl
  import i2cseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       msgValid,
  input  logic       msgRead,
  input  logic       msgLast,
  input  logic       msgLenZero,
  input  logic       wrValid,
  input  logic       cmdReady,
  input  logic       txEmpty,
  input  logic       txAbort,
  input  logic       abrtAddrNack,
  input  logic       abrtDataNack,
  input  logic       rxNotEmpty,
  input  logic       curRead,
  input  logic       curLast,
  input  logic       remOne,
  input  logic       errSeen,
  input  logic       tmrExpired,
  output logic       msgReady,
  output logic       wrReady,
  output logic       cmdValid,
  output logic       rxPop,
  output logic       done,
  output seqStrobe_t sb
);
  seqState_t st, nxt;
  seqState_t endMsg;

  assign endMsg = curLast ? S_FINISH : S_IDLE;

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt = st;
    sb = '0;
    msgReady = 1'b0;
    wrReady = 1'b0;
    cmdValid = 1'b0;
    rxPop = 1'b0;
    done = 1'b0;
    unique case (st)
      S_IDLE: begin
        msgReady = 1'b1;
        if (msgValid) begin
          sb.loadMsg = 1'b1;
          if (errSeen) begin
            if (!msgRead && !msgLenZero) nxt = S_SKIP;
            else if (msgLast)            nxt = S_FINISH;
          end else if (msgLenZero) begin
            sb.errSet = 1'b1;
            sb.errCode = ST_ABORT;
            if (msgLast) nxt = S_FINISH;
          end else begin
            nxt = S_ISSUE;
          end
        end
      end
      S_ISSUE: begin
        cmdValid = curRead ? 1'b1 : wrValid;
        wrReady = !curRead && cmdReady;
        if (cmdValid && cmdReady) begin
          sb.tmrClr = 1'b1;
          sb.cmdSent = 1'b1;
          if (curRead) nxt = S_WAIT_RX;
          else begin
            sb.decRem = 1'b1;
            if (remOne) nxt = S_WAIT_TX;
          end
        end else if (!cmdReady) begin
          if (tmrExpired) begin
            sb.tmrClr = 1'b1;
            sb.errSet = 1'b1;
            sb.errCode = ST_SEQ_TIMEOUT;
            nxt = curRead ? endMsg : S_SKIP;
          end else begin
            sb.tmrInc = 1'b1;
          end
        end
      end
      S_WAIT_TX: begin
        if (txEmpty) begin
          sb.tmrClr = 1'b1;
          nxt = endMsg;
          if (txAbort) begin
            sb.errSet = 1'b1;
            sb.errCode = abrtDataNack ? ST_DATA_NACK :
                         abrtAddrNack ? ST_ADDR_NACK : ST_ABORT;
          end
        end else if (tmrExpired) begin
          sb.tmrClr = 1'b1;
          sb.errSet = 1'b1;
          sb.errCode = ST_SEQ_TIMEOUT;
          nxt = endMsg;
        end else begin
          sb.tmrInc = 1'b1;
        end
      end
      S_WAIT_RX: begin
        if (abrtAddrNack) begin
          sb.tmrClr = 1'b1;
          sb.errSet = 1'b1;
          sb.errCode = ST_ADDR_NACK;
          nxt = endMsg;
        end else if (rxNotEmpty) begin
          rxPop = 1'b1;
          sb.tmrClr = 1'b1;
          sb.decRem = 1'b1;
          nxt = remOne ? endMsg : S_ISSUE;
        end else if (tmrExpired) begin
          sb.tmrClr = 1'b1;
          sb.errSet = 1'b1;
          sb.errCode = ST_SEQ_TIMEOUT;
          nxt = endMsg;
        end else begin
          sb.tmrInc = 1'b1;
        end
      end
      S_SKIP: begin
        wrReady = 1'b1;
        if (wrValid) begin
          sb.decRem = 1'b1;
          if (remOne) nxt = endMsg;
        end
      end
      S_FINISH: begin
        done = 1'b1;
        sb.txnClr = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end
endmodule

// File: rtl/i2cseq_dp.sv
`timescale 1ns/1ps
module i2cseq_dp
  import i2cseq_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int TIMEOUT_CYC = 4_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        sb,
  input  logic [ADDR_W-1:0] msgAddr,
  input  logic              msgRead,
  input  logic [LEN_W-1:0]  msgLen,
  input  logic              msgLast,
  input  logic [BYTE_W-1:0] wrData,
  output logic              msgLenZero,
  output logic [CMD_W-1:0]  cmdWord,
  output logic              curRead,
  output logic              curLast,
  output logic              remOne,
  output logic              tmrExpired,
  output logic              errSeen,
  output logic [STAT_W-1:0] status
);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);

  logic [ADDR_W-1:0] curAddr, refAddr;
  logic              refRead, inTxn, restartPend;
  logic [LEN_W-1:0]  rem;
  logic [TMR_W-1:0]  timer;
  cmdWord_t          word;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0; refAddr <= '0; refRead <= 1'b0; curRead <= 1'b0;
      curLast <= 1'b0; inTxn <= 1'b0; restartPend <= 1'b0; rem <= '0;
      timer <= '0; errSeen <= 1'b0; status <= '0;
    end else begin
      if (sb.loadMsg) begin
        curAddr <= msgAddr;
        curRead <= msgRead;
        curLast <= msgLast;
        rem <= msgLen;
        restartPend <= inTxn && ((msgAddr != refAddr) || (msgRead != refRead));
        refAddr <= msgAddr;
        refRead <= msgRead;
        inTxn <= 1'b1;
      end
      if (sb.cmdSent) restartPend <= 1'b0;
      if (sb.decRem)  rem <= rem - LEN_W'(1);
      if (sb.tmrClr)      timer <= '0;
      else if (sb.tmrInc) timer <= timer + TMR_W'(1);
      if (sb.errSet) begin
        status <= status | sb.errCode;
        errSeen <= 1'b1;
      end
      if (sb.txnClr) begin
        status <= '0;
        errSeen <= 1'b0;
        inTxn <= 1'b0;
      end
    end
  end

  assign msgLenZero = (msgLen == '0);
  assign remOne = (rem == LEN_W'(1));
  assign tmrExpired = (timer == TMR_W'(TIMEOUT_CYC - 1));

  always_comb begin
    word.restart = restartPend;
    word.stop = curLast && remOne;
    word.rd = curRead;
    word.addr = curAddr;
    word.rsvd = 1'b0;
    word.data = curRead ? '0 : wrData;
  end
  assign cmdWord = word;
endmodule

// File: rtl/i2c_msg_seq.sv
`timescale 1ns/1ps
module i2c_msg_seq
  import i2cseq_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int TIMEOUT_CYC = 4_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msgValid,
  output logic              msgReady,
  input  logic [ADDR_W-1:0] msgAddr,
  input  logic              msgRead,
  input  logic [LEN_W-1:0]  msgLen,
  input  logic              msgLast,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [BYTE_W-1:0] wrData,
  output logic              rdValid,
  output logic [BYTE_W-1:0] rdData,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [CMD_W-1:0]  cmdWord,
  input  logic              txEmpty,
  input  logic              txAbort,
  input  logic              abrtAddrNack,
  input  logic              abrtDataNack,
  input  logic              rxNotEmpty,
  input  logic [BYTE_W-1:0] rxData,
  output logic              rxPop,
  output logic              done,
  output logic [STAT_W-1:0] status
);
  seqStrobe_t sb;
  logic msgLenZero, curRead, curLast, remOne, tmrExpired, errSeen;

  i2cseq_ctrl u_ctrl (
    .clk, .rstN, .msgValid, .msgRead, .msgLast, .msgLenZero, .wrValid,
    .cmdReady, .txEmpty, .txAbort, .abrtAddrNack, .abrtDataNack,
    .rxNotEmpty, .curRead, .curLast, .remOne, .errSeen, .tmrExpired,
    .msgReady, .wrReady, .cmdValid, .rxPop, .done, .sb
  );

  i2cseq_dp #(.LEN_W(LEN_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_dp (
    .clk, .rstN, .sb, .msgAddr, .msgRead, .msgLen, .msgLast, .wrData,
    .msgLenZero, .cmdWord, .curRead, .curLast, .remOne, .tmrExpired,
    .errSeen, .status
  );

  assign rdValid = rxPop;
  assign rdData = rxData;
endmodule

// File: rtl/i2cseq_checker.sv
`timescale 1ns/1ps
module i2cseq_checker
  import i2cseq_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int TIMEOUT_CYC = 4_000_000
) (
  input logic             clk,
  input logic             rstN,
  input logic             msgValid,
  input logic             msgReady,
  input logic [LEN_W-1:0] msgLen,
  input logic             cmdValid,
  input logic             cmdReady,
  input logic [CMD_W-1:0] cmdWord,
  input logic             rxPop,
  input logic             rxNotEmpty,
  input logic             done
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 2);
  logic [CNT_W-1:0] stallCnt;
  logic sentAny, stopSent;
  cmdWord_t w;
  assign w = cmdWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallCnt <= '0; sentAny <= 1'b0; stopSent <= 1'b0;
    end else begin
      stallCnt <= (cmdValid && !cmdReady) ? stallCnt + CNT_W'(1) : '0;
      if (done) begin
        sentAny <= 1'b0; stopSent <= 1'b0;
      end else if (cmdValid && cmdReady) begin
        sentAny <= 1'b1;
        if (w.stop) stopSent <= 1'b1;
      end
    end
  end

  AST_FIRST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !sentAny) |-> !w.restart); // R3
  AST_NOTHING_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    stopSent |-> !cmdValid); // R4
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> rxNotEmpty); // R6
  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |-> (stallCnt < CNT_W'(TIMEOUT_CYC))); // R7
  AST_ZERO_LEN_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgReady && msgLen == '0) |=> !cmdValid); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
endmodule

bind i2c_msg_seq i2cseq_checker #(.LEN_W(LEN_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (.*);

// File: tb/i2c_msg_seq_bench.sv
`timescale 1ns/1ps
module i2c_msg_seq_bench;
  import i2cseq_pkg::*;
  localparam int LEN_W = 4;
  localparam int TMO = 24;
  localparam int FDEPTH = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, msgValid, msgReady, msgRead, msgLast, wrValid, wrReady;
  logic [6:0] msgAddr;
  logic [LEN_W-1:0] msgLen;
  logic [7:0] wrData, rdData, rxData;
  logic rdValid, cmdValid, cmdReady, txEmpty, txAbort, abrtAddrNack, abrtDataNack;
  logic rxNotEmpty, rxPop, done;
  logic [CMD_W-1:0] cmdWord;
  logic [4:0] status;

  i2c_msg_seq #(.LEN_W(LEN_W), .TIMEOUT_CYC(TMO)) u_i2c_msg_seq (.*);

  int nChecks = 0, nFail = 0;
  logic [6:0] dA[$]; bit dR[$]; int dL[$]; bit dLast[$];
  logic [7:0] wq[$], expRd[$], rxq[$];
  logic [CMD_W-1:0] expCmd[$], mq[$];
  bit freeze = 0, noRx = 0, readsOk = 1;
  bit kAbort = 0, kAddr = 0, kData = 0;
  bit haveRef = 0, refR = 0;
  logic [6:0] refA = '0;
  logic [7:0] rxSeq = 8'h90, expSeq = 8'h90, wSeed = 8'h30;
  int cyc = 0, doneCnt = 0, doneCyc = 0;
  logic [4:0] doneStat = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Master and stream model, evaluated once per cycle away from the edge
  initial forever begin
    @(negedge clk);
    msgValid = dA.size() > 0;
    msgAddr  = msgValid ? dA[0] : '0;
    msgRead  = msgValid ? dR[0] : 1'b0;
    msgLen   = msgValid ? LEN_W'(dL[0]) : '0;
    msgLast  = msgValid ? dLast[0] : 1'b0;
    wrValid  = wq.size() > 0;
    wrData   = wrValid ? wq[0] : '0;
    cmdReady = !freeze && (mq.size() < FDEPTH);
    txEmpty  = mq.size() == 0;
    rxNotEmpty = rxq.size() > 0;
    rxData   = rxNotEmpty ? rxq[0] : '0;
    txAbort = kAbort; abrtAddrNack = kAddr; abrtDataNack = kData;
    #1;
    if (rstN) begin
      cyc++;
      if (msgValid && msgReady) begin
        void'(dA.pop_front()); void'(dR.pop_front()); void'(dL.pop_front()); void'(dLast.pop_front());
      end
      if (wrValid && wrReady) void'(wq.pop_front());
      if (cmdValid && cmdReady) begin
        if (expCmd.size() == 0) chk("R2/R8 unexpected command", 32'(cmdWord), 32'hFFFF_FFFF);
        else chk("R2/R3/R4 command word", 32'(cmdWord), 32'(expCmd.pop_front()));
        mq.push_back(cmdWord);
      end
      if (rxPop) begin
        if (expRd.size() == 0) chk("R6 unexpected read byte", 32'(rdData), 32'hFFFF_FFFF);
        else chk("R6 read byte", {31'd0, rdValid} << 8 | 32'(rdData), 32'h100 | 32'(expRd.pop_front()));
        void'(rxq.pop_front());
      end
      if (done) begin doneCnt++; doneStat = status; doneCyc = cyc; end
      if (!freeze && mq.size() > 0 && (cyc % 3 == 0)) begin
        cmdWord_t w;
        w = mq.pop_front();
        if (w.rd && !noRx) begin rxq.push_back(rxSeq); rxSeq++; end
      end
    end
  end

  task automatic startTxn();
    @(posedge clk);
    haveRef = 0; doneCnt = 0; freeze = 0; noRx = 0; readsOk = 1;
    kAbort = 0; kAddr = 0; kData = 0;
    mq.delete(); rxq.delete(); expSeq = rxSeq;
  endtask

  task automatic addMsg(input logic [6:0] a, input bit rd, input int len, input bit last, input int nExp);
    bit rs;
    rs = haveRef && (a != refA || rd != refR);
    haveRef = 1; refA = a; refR = rd;
    dA.push_back(a); dR.push_back(rd); dL.push_back(len); dLast.push_back(last);
    for (int i = 0; i < len; i++) begin
      logic [7:0] d;
      d = rd ? 8'h00 : wSeed;
      if (!rd) begin wq.push_back(d); wSeed++; end
      if (i < nExp) begin
        expCmd.push_back({rs && i == 0, last && i == len - 1, rd, a, 1'b0, d});
        if (rd && readsOk) begin expRd.push_back(expSeq); expSeq++; end
      end
    end
  endtask

  task automatic finishTxn(input string req, input logic [4:0] expStat);
    int n;
    n = 0;
    while (doneCnt == 0 && n < 3000) begin @(posedge clk); n++; end
    if (doneCnt == 0) chk({req, " watchdog: done never seen"}, 32'd0, 32'd1);
    repeat (4) @(posedge clk);
    chk({req, " status (R10)"}, 32'(doneStat), 32'(expStat));
    chk({req, " single done pulse (R10)"}, doneCnt, 1);
    chk({req, " missing commands"}, expCmd.size(), 0);
    chk({req, " missing read bytes"}, expRd.size(), 0);
    chk({req, " descriptors consumed (R8)"}, dA.size(), 0);
    chk({req, " write bytes consumed (R8)"}, wq.size(), 0);
    expCmd.delete(); expRd.delete(); dA.delete(); dR.delete(); dL.delete(); dLast.delete(); wq.delete();
  endtask

  int startCyc;
  initial begin
    rstN = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #2;
    chk("R1 reset msgReady", 32'(msgReady), 1);
    chk("R1 reset cmdValid", 32'(cmdValid), 0);
    chk("R1 reset done", 32'(done), 0);

    // R2 R4: single write with STOP on last byte
    startTxn(); addMsg(7'h50, 0, 3, 1, 3); finishTxn("R2 single write", 5'h00);
    // R6: single read
    startTxn(); addMsg(7'h50, 1, 2, 1, 2); finishTxn("R6 single read", 5'h00);
    // R3: restart on direction and address changes, reference follows
    startTxn();
    addMsg(7'h50, 0, 2, 0, 2); addMsg(7'h50, 0, 1, 0, 1); addMsg(7'h50, 1, 2, 0, 2);
    addMsg(7'h21, 0, 1, 0, 1); addMsg(7'h50, 0, 1, 1, 1);
    finishTxn("R3 restart sequence", 5'h00);
    // R5 R8: data NACK has priority; trailing read drained
    startTxn(); kAbort = 1; kData = 1; kAddr = 1;
    addMsg(7'h33, 0, 2, 0, 2); addMsg(7'h33, 1, 2, 1, 0);
    finishTxn("R5 data nack", 5'h02);
    // R5: address NACK on write
    startTxn(); kAbort = 1; kAddr = 1;
    addMsg(7'h34, 0, 1, 1, 1); finishTxn("R5 addr nack write", 5'h01);
    // R5: abort without known source
    startTxn(); kAbort = 1;
    addMsg(7'h35, 0, 2, 1, 2); finishTxn("R5 other abort", 5'h10);
    // R6 R8: address NACK on read, later write drained
    startTxn(); kAddr = 1; readsOk = 0;
    addMsg(7'h36, 1, 3, 0, 1); addMsg(7'h36, 0, 2, 1, 0);
    finishTxn("R6 read addr nack", 5'h01);
    // R7 R8: command FIFO stuck full
    startTxn(); freeze = 1; startCyc = cyc;
    addMsg(7'h37, 0, 3, 0, 0); addMsg(7'h38, 0, 2, 1, 0);
    finishTxn("R7 tx fifo timeout", 5'h08);
    chk("R7 timeout not before window", 32'(doneCyc - startCyc >= TMO), 1);
    // R7: receive FIFO never fills
    startTxn(); noRx = 1; readsOk = 0;
    addMsg(7'h39, 1, 2, 1, 1); finishTxn("R7 rx timeout", 5'h08);
    // R9: lone zero-length message
    startTxn(); addMsg(7'h3A, 0, 0, 1, 0); finishTxn("R9 zero length", 5'h10);
    // R9 R8: zero length in the middle
    startTxn();
    addMsg(7'h3B, 0, 1, 0, 1); addMsg(7'h3B, 0, 0, 0, 0); addMsg(7'h3C, 0, 2, 1, 0);
    finishTxn("R9 zero length mid", 5'h10);
    // R10 R3: clean transaction after errors, first message without restart
    startTxn(); addMsg(7'h3C, 1, 1, 0, 1); addMsg(7'h3C, 0, 2, 1, 2);
    finishTxn("R10 recovery", 5'h00);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    #(5 * 150000);
    nChecks++; nFail++;
    $display("FAIL global watchdog (R10) actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule